// File: doc/BRIEF.md
# Mask-Based Barrel Shifter with Overflow and Zero Flags

This block is a purely combinational shifter of `W` bits. It performs six operations: logical, arithmetic and rotating shifts in either direction. The operand, the shift amount and a 3-bit operation code are its inputs. The result, an overflow flag and a zero flag are its outputs. The block has no clock and no internal state, so it drops into an execute stage between pipeline registers that the surrounding logic owns.

All six operations go through one logarithmic right rotator. Left operations mirror the operand before the rotator and mirror the rotator output again. Shifts differ from rotations only through a pass mask computed from the amount. Result positions that the mask clears are loaded with a fill value.

The overflow flag and the zero flag are both derived from the operand and the masks. They do not wait for the rotated data, so they settle no later than the result does.

Top module: `mask_shifter`

## Requirements
- R1: The operation code `op[2:0]` is {left, rotate, arith}. 000 is logical right, 001 is arithmetic right, 010/011 is rotate right, 100 is logical left, 101 is arithmetic left, 110/111 is rotate left.
- R2: Logical right by `amt` gives `a >> amt`, with zeros in the top `amt` bits.
- R3: Rotate right gives `(a >> amt) | (a << (W-amt))`, and rotate left gives `(a << amt) | (a >> (W-amt))`. No bit is lost.
- R4: Arithmetic right fills the top `amt` result bits with `a[W-1]`. The remaining bits are `a >> amt`.
- R5: Logical left gives `a << amt`, with zeros in the low `amt` bits.
- R6: Arithmetic left gives `y[W-1] = a[W-1]`. The bits `y[W-2:0]` are bits `W-2..0` of `a << amt`.
- R7: `ovf` is 1 only for arithmetic left. It is 1 exactly when some bit `a[i]`, with `W-1-amt <= i <= W-2`, differs from `a[W-1]`.
- R8: `zero` is 1 exactly when `y` is all zeros. It is formed from the operand and a survivor mask, not from `y`.
- R9: With `amt = 0`, every operation returns `y = a` and `ovf = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Operand |
| amt | input | $clog2(W) | Unsigned shift or rotate amount, 0 to W-1 |
| op | input | 3 | Operation code {left, rotate, arith} |
| y | output | W | Shifted or rotated result |
| ovf | output | 1 | Arithmetic-left overflow |
| zero | output | 1 | Result is all zeros |

## Verification
Each output depends only on the current inputs, so any fault in the decode, the masks or a rotator stage shows at the ports as soon as a mismatching input is applied.

- A broken rotator stage corrupts `y` only for amounts with that bit set. Sweeping every amount against every operation code therefore isolates it.
- A wrong mask bit appears either as a wrong fill in `y` or as a disagreement between `zero` and the result.
- A wrong overflow window shows only for arithmetic left, and only on operands whose bits near the sign differ from it. This is why alternating and near-sign patterns are applied alongside uniform ones.

// File: rtl/mask_shifter_pkg.sv
package mask_shifter_pkg;

  // Operation code bit positions: {left, rotate, arith}
  localparam int OpLeftBit  = 2;
  localparam int OpRotBit   = 1;
  localparam int OpArithBit = 0;

  // Strobes from the decode to the datapath and mask logic
  typedef struct packed {
    logic left;    // mirror data around the rotator
    logic rotate;  // keep every rotated bit
    logic sra;     // arithmetic right: fill with sign
    logic sla;     // arithmetic left: keep sign, check overflow
  } shCtrl_t;

endpackage

// File: rtl/mask_shifter_ctrl.sv
module mask_shifter_ctrl
  import mask_shifter_pkg::*;
(
  input  logic [2:0] op,
  output shCtrl_t    ctl
);

  logic opLeft;
  logic opRot;
  logic opArith;

  assign opLeft  = op[OpLeftBit];
  assign opRot   = op[OpRotBit];
  assign opArith = op[OpArithBit];

  always_comb begin
    ctl.left   = opLeft;
    ctl.rotate = opRot;
    ctl.sra    = !opLeft && !opRot && opArith;
    ctl.sla    =  opLeft && !opRot && opArith;
  end

  // R1: rotation excludes both arithmetic modes, which exclude each other
  always_comb begin
    strobe_excl_chk: assert ($onehot0({ctl.rotate, ctl.sra, ctl.sla}))
      else $error("R1 strobe decode not exclusive");
  end

endmodule

// File: rtl/mask_shifter_masks.sv
module mask_shifter_masks
  import mask_shifter_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  shCtrl_t       ctl,
  output logic [W-1:0]  pMask,
  output logic          ovf,
  output logic          zero
);

  localparam logic [AW:0] WidthL = (AW+1)'(W);

  logic [W-1:0] fMask;     // ones in positions below W-amt
  logic [W-1:0] survMask;  // operand bits that reach the result
  logic [W-2:0] diffSign;  // operand bits unlike the sign

  // Shift mask: bit i set when i + amt < W
  for (genvar i = 0; i < W; i++) begin : g_fmask
    localparam logic [AW:0] Idx = (AW+1)'(i);
    assign fMask[i] = (Idx + {1'b0, amt}) < WidthL;
  end

  assign pMask = fMask | {W{ctl.rotate}};

  // Survivor mask in operand coordinates
  for (genvar i = 0; i < W; i++) begin : g_surv
    if (i == W-1) begin : g_top
      always_comb begin
        if (!ctl.left)    survMask[i] = pMask[W-1-i];
        else if (ctl.sla) survMask[i] = 1'b1;
        else              survMask[i] = pMask[i];
      end
    end else begin : g_low
      always_comb begin
        if (!ctl.left)    survMask[i] = pMask[W-1-i];
        else if (ctl.sla) survMask[i] = fMask[i+1];
        else              survMask[i] = pMask[i];
      end
    end
  end

  assign zero     = ~|(a & survMask);
  assign diffSign = a[W-2:0] ^ {(W-1){a[W-1]}};
  assign ovf      = ctl.sla & (|(diffSign & ~fMask[W-1:1]));

  // R7: overflow only on arithmetic left
  always_comb begin
    ovf_mode_chk: assert (!ovf || ctl.sla)
      else $error("R7 overflow outside arithmetic left");
  end

  // R2: shift mask holds exactly W-amt ones
  always_comb begin
    fmask_count_chk: assert ($countones(fMask) == W - int'(amt))
      else $error("R2 shift mask population wrong");
  end

endmodule

// File: rtl/mask_shifter_dp.sv
module mask_shifter_dp
  import mask_shifter_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  shCtrl_t       ctl,
  input  logic [W-1:0]  pMask,
  output logic [W-1:0]  y
);

  logic [W-1:0] aMir;
  logic [W-1:0] stg [AW+1];
  logic [W-1:0] tRes;
  logic         fill;

  // Input mirror for left operations
  for (genvar i = 0; i < W; i++) begin : g_in_mir
    assign aMir[i] = ctl.left ? a[W-1-i] : a[i];
  end

  assign stg[0] = aMir;

  // Logarithmic right rotator: stage k moves by 2**k
  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int Sh = 1 << k;
    assign stg[k+1] = amt[k] ? {stg[k][Sh-1:0], stg[k][W-1:Sh]} : stg[k];
  end

  assign fill = ctl.sra & a[W-1];

  // Masked fill; position 0 carries the sign for arithmetic left
  for (genvar i = 0; i < W; i++) begin : g_fill
    if (i == 0) begin : g_lsb
      assign tRes[i] = ctl.sla ? a[W-1] : (pMask[i] ? stg[AW][i] : fill);
    end else begin : g_rest
      assign tRes[i] = pMask[i] ? stg[AW][i] : fill;
    end
  end

  // Output mirror
  for (genvar i = 0; i < W; i++) begin : g_out_mir
    assign y[i] = ctl.left ? tRes[W-1-i] : tRes[i];
  end

  // R3: rotations keep the operand's population
  always_comb begin
    rot_count_chk: assert (!ctl.rotate || ($countones(y) == $countones(a)))
      else $error("R3 rotation lost bits");
  end

  // R6: arithmetic left keeps the sign in place
  always_comb begin
    sla_sign_chk: assert (!ctl.sla || (y[W-1] == a[W-1]))
      else $error("R6 sign not preserved");
  end

endmodule

// File: rtl/mask_shifter.sv
module mask_shifter
  import mask_shifter_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    op,
  output logic [W-1:0]  y,
  output logic          ovf,
  output logic          zero
);

  shCtrl_t      ctl;
  logic [W-1:0] pMask;

  mask_shifter_ctrl u_ctrl (
    .op  (op),
    .ctl (ctl)
  );

  mask_shifter_masks #(.W(W), .AW(AW)) u_masks (
    .a     (a),
    .amt   (amt),
    .ctl   (ctl),
    .pMask (pMask),
    .ovf   (ovf),
    .zero  (zero)
  );

  mask_shifter_dp #(.W(W), .AW(AW)) u_dp (
    .a     (a),
    .amt   (amt),
    .ctl   (ctl),
    .pMask (pMask),
    .y     (y)
  );

  // R8: mask-derived zero flag agrees with the rotated result
  always_comb begin
    zero_flag_chk: assert (zero == (y == '0))
      else $error("R8 zero flag mismatch");
  end

  // R9: zero amount is identity without overflow
  always_comb begin
    ident_chk: assert ((amt != '0) || ((y == a) && !ovf))
      else $error("R9 zero amount not identity");
  end

endmodule

// File: tb/mask_shifter_tb_top.sv
module mask_shifter_tb_top;

  localparam int W       = 16;
  localparam int AW      = $clog2(W);
  localparam int ClkHalf = 5;

  typedef struct {
    logic [W-1:0] a;
    int           b;
    logic [2:0]   op;
    logic [W-1:0] y;
    logic         ovf;
    logic         zero;
  } sbItem_t;

  logic          clk = 1'b0;
  logic [W-1:0]  aIn = '0;
  logic [AW-1:0] amtIn = '0;
  logic [2:0]    opIn = '0;
  logic [W-1:0]  yOut;
  logic          ovfOut;
  logic          zeroOut;

  int      checks = 0;
  int      errors = 0;
  bit      finished = 1'b0;
  sbItem_t sbq[$];

  always #ClkHalf clk = ~clk;

  mask_shifter #(.W(W)) dut_i (
    .a    (aIn),
    .amt  (amtIn),
    .op   (opIn),
    .y    (yOut),
    .ovf  (ovfOut),
    .zero (zeroOut)
  );

  function automatic string reqTag(logic [2:0] op);
    case (op)
      3'b000:         return "R1 R2";
      3'b001:         return "R1 R4";
      3'b100:         return "R1 R5";
      3'b101:         return "R1 R6";
      default:        return "R1 R3";
    endcase
  endfunction

  function automatic logic [W-1:0] modelY(logic [W-1:0] a, int b, logic [2:0] op);
    logic [W-1:0] t;
    case (op)
      3'b000: return a >> b;
      3'b001: return W'($signed(a) >>> b);
      3'b010, 3'b011: return (a >> b) | ((b == 0) ? '0 : (a << (W - b)));
      3'b100: return a << b;
      3'b101: begin t = a << b; return {a[W-1], t[W-2:0]}; end
      default: return (a << b) | ((b == 0) ? '0 : (a >> (W - b)));
    endcase
  endfunction

  function automatic logic modelOvf(logic [W-1:0] a, int b, logic [2:0] op);
    logic o = 1'b0;
    if (op != 3'b101) return 1'b0;
    for (int i = W - 1 - b; i <= W - 2; i++)
      if (a[i] != a[W-1]) o = 1'b1;
    return o;
  endfunction

  task automatic drive(logic [W-1:0] a, int b, logic [2:0] op);
    sbItem_t it;
    @(posedge clk);
    aIn   <= a;
    amtIn <= AW'(b);
    opIn  <= op;
    it.a = a; it.b = b; it.op = op;
    it.y    = modelY(a, b, op);
    it.ovf  = modelOvf(a, b, op);
    it.zero = (it.y == '0);
    sbq.push_back(it);
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      sbItem_t it;
      it = sbq.pop_front();
      checks++;
      if (yOut !== it.y) begin
        errors++;
        $display("FAIL %s y a=%h b=%0d op=%b actual=%h expected=%h",
                 reqTag(it.op), it.a, it.b, it.op, yOut, it.y);
      end
      checks++;
      if (ovfOut !== it.ovf) begin
        errors++;
        $display("FAIL R7 ovf a=%h b=%0d op=%b actual=%b expected=%b",
                 it.a, it.b, it.op, ovfOut, it.ovf);
      end
      checks++;
      if (zeroOut !== it.zero) begin
        errors++;
        $display("FAIL R8 zero a=%h b=%0d op=%b actual=%b expected=%b",
                 it.a, it.b, it.op, zeroOut, it.zero);
      end
      if (it.b == 0) begin
        checks++;  // R9 identity on zero amount
        if (yOut !== it.a || ovfOut !== 1'b0) begin
          errors++;
          $display("FAIL R9 identity op=%b actual=%h/%b expected=%h/0",
                   it.op, yOut, ovfOut, it.a);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {(W/2){2'b10}};
    pats[3] = {(W/2){2'b01}};
    pats[4] = {1'b1, {(W-2){1'b0}}, 1'b1};
    pats[5] = {1'b0, {(W-1){1'b1}}};

    // Initial state: all-zero operand, logical right, zero flag set (R8)
    drive('0, 0, 3'b000);

    // Every code, every amount, fixed patterns (R1-tagged sweeps)
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 8; o++)
        for (int b = 0; b < W; b++)
          drive(pats[p], b, 3'(o));

    // Sign-boundary overflow cases for arithmetic left (R7)
    drive({1'b0, 1'b1, {(W-2){1'b0}}}, 1, 3'b101);  // overflow
    drive({1'b0, 1'b0, 1'b1, {(W-3){1'b0}}}, 1, 3'b101);  // none
    drive({1'b1, {(W-1){1'b0}}}, W-1, 3'b101);  // overflow

    // Random operands
    for (int n = 0; n < 3000; n++)
      drive(W'($urandom), int'($urandom_range(W-1, 0)), 3'($urandom_range(7, 0)));

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule